// File: doc/BRIEF.md
# Word-Level Spare Memory Repair Unit

This unit sits between a processor and an external system memory and hides individual memory words that have failed permanently. On a start pulse it runs a self-test over the whole address range. At each location it writes a fixed data word and reads it back, then writes the bitwise inverse of that word and reads it back. Any location where either read-back differs from what was written is a hard fault. That location is given one entry in a small on-chip store that is fully associative and holds spare words. Each entry keeps a valid bit, the faulty address as its tag, and one replacement data word.

After the test, every processor access goes to the external memory and, in the same cycle, is looked up by address in the spare store. On a tag match a read returns the spare word instead of the external data, and a write updates the spare word. The write is also passed on to the external memory, where its value no longer matters. The tag compare and the data select are combinational, so a repaired word is reached with no extra cycles. While the self-test runs, the processor side is stalled and its requests are ignored.

Top module: `spare_word_repair`

## Requirements
- R1: While `rst` is high and directly after it, `mapped_count` is 0, `spare_valid` is all zeros, and `test_done`, `test_busy`, `spare_overflow` and `cpu_stall` are 0.
- R2: The self-test visits every address from 0 up to the last one. At each address it writes 16'hA5A5, reads it back, then writes 16'h5A5A and reads it back, so a healthy location holds 16'h5A5A once the test ends.
- R3: An address that fails either read-back is mapped exactly once, into the lowest-numbered free spare entry. Addresses are mapped in increasing order, so after a test `spare_valid` has its low `mapped_count` bits set.
- R4: A failing address found while all spares are in use is left unmapped and sets `spare_overflow`. The flag stays set until the next test start.
- R5: From the cycle after a start pulse until the test finishes, `test_busy` and `cpu_stall` are 1, and processor requests do not reach the external memory. After the last address, `test_done` goes to 1 and stays there until the next start.
- R6: A processor access whose address matches no valid spare goes to the external memory unchanged, and a read returns the external data.
- R7: A processor write that matches a valid spare updates that spare word. Later reads of that address return the spare word, whatever the external memory returns there.
- R8: A newly mapped spare entry holds 16'h0000 until the processor writes it.
- R9: A start pulse accepted while the test is idle or done clears all spare entries, `mapped_count` and `spare_overflow` at the same edge at which the test begins.
- R10: `cpu_rdata` is valid in the same cycle as the request. Hit detection and data selection add no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_start | input | 1 | One-cycle pulse that starts the self-test |
| test_busy | output | 1 | Self-test in progress |
| test_done | output | 1 | Self-test has finished |
| spare_overflow | output | 1 | Sticky: a fault was found with no spare free |
| mapped_count | output | $clog2(NUM_SPARES+1) | Number of spare entries in use |
| spare_valid | output | NUM_SPARES | Valid bit of each spare entry |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data, spare word on a hit |
| cpu_stall | output | 1 | Processor must hold off |
| mem_en | output | 1 | External memory access enable |
| mem_we | output | 1 | External memory write enable |
| mem_addr | output | ADDR_W | External memory address |
| mem_wdata | output | DATA_W | External memory write data |
| mem_rdata | input | DATA_W | External memory read data (combinational) |

## Verification
The memory model in the bench has faults of several kinds. Some fail only the first pattern, some only the inverse, and one fails both. A design that skipped the inverse pass would leave the inverse-only faults unmapped. A design that mapped once per failed pass would report six spares where there are five faulty words. The bench reads repaired words back after writing them, at addresses whose external copy is corrupt, so a hit mux that favoured the external data shows up at once. A second test run has more faults than spares. It checks that the map was cleared at start, that the lowest eight faulty addresses took the spares in order, that the flag became sticky, and that the surplus faulty address still shows its corrupted external value. A processor write sent in the middle of the test is checked later at that address, which catches a design that let it through the stall.

// File: rtl/spare_repair_pkg.sv
package spare_repair_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WR_TRUE  = 3'd1,
        ST_RD_TRUE  = 3'd2,
        ST_WR_COMP  = 3'd3,
        ST_RD_COMP  = 3'd4,
        ST_NEXT     = 3'd5,
        ST_DONE     = 3'd6
    } sweep_state_e;

    localparam logic [7:0] SWEEP_BYTE = 8'hA5;

    // Repeat one byte across a wide word; callers slice to their data width.
    function automatic logic [63:0] spread_byte(logic [7:0] b);
        return {8{b}};
    endfunction

    function automatic logic is_resting(sweep_state_e s);
        return (s == ST_IDLE) || (s == ST_DONE);
    endfunction

endpackage

// File: rtl/march_sequencer.sv
module march_sequencer
    import spare_repair_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              clear_map,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              alloc_req,
    output logic [ADDR_W-1:0] alloc_addr
);

    localparam logic [DATA_W-1:0] PAT_TRUE = DATA_W'(spread_byte(SWEEP_BYTE));
    localparam logic [DATA_W-1:0] PAT_COMP = ~PAT_TRUE;
    localparam logic [ADDR_W-1:0] ADDR_LAST = {ADDR_W{1'b1}};

    sweep_state_e      state;
    logic [ADDR_W-1:0] addr;
    logic              fail_seen;
    logic              mismatch;
    logic              accept;

    assign accept = start && is_resting(state);

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = PAT_TRUE;
        mismatch  = 1'b0;
        unique case (state)
            ST_WR_TRUE: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            ST_RD_TRUE: begin
                mem_en   = 1'b1;
                mismatch = (rd_data != PAT_TRUE);
            end
            ST_WR_COMP: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = PAT_COMP;
            end
            ST_RD_COMP: begin
                mem_en    = 1'b1;
                mem_wdata = PAT_COMP;
                mismatch  = (rd_data != PAT_COMP);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            addr      <= '0;
            fail_seen <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state     <= ST_WR_TRUE;
                        addr      <= '0;
                        fail_seen <= 1'b0;
                    end
                end
                ST_WR_TRUE: state <= ST_RD_TRUE;
                ST_RD_TRUE: begin
                    fail_seen <= fail_seen | mismatch;
                    state     <= ST_WR_COMP;
                end
                ST_WR_COMP: state <= ST_RD_COMP;
                ST_RD_COMP: begin
                    fail_seen <= fail_seen | mismatch;
                    state     <= ST_NEXT;
                end
                ST_NEXT: begin
                    fail_seen <= 1'b0;
                    if (addr == ADDR_LAST) begin
                        state <= ST_DONE;
                    end else begin
                        addr  <= addr + 1'b1;
                        state <= ST_WR_TRUE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_addr   = addr;
    assign busy       = !is_resting(state);
    assign done       = (state == ST_DONE);
    assign clear_map  = accept;
    // One request per address, after both passes, so a word failing twice maps once.
    assign alloc_req  = (state == ST_NEXT) && fail_seen;
    assign alloc_addr = addr;

endmodule

// File: rtl/spare_tag_store.sv
module spare_tag_store #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16,
    parameter int NUM_SPARES = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                clear,
    input  logic [ADDR_W-1:0]                   look_addr,
    input  logic                                wr_en,
    input  logic [DATA_W-1:0]                   wr_data,
    output logic                                hit,
    output logic [DATA_W-1:0]                   hit_data,
    input  logic                                alloc_req,
    input  logic [ADDR_W-1:0]                   alloc_addr,
    output logic [NUM_SPARES-1:0]               valid_vec,
    output logic [$clog2(NUM_SPARES+1)-1:0]     used_count,
    output logic                                overflow
);

    localparam int IDX_W = (NUM_SPARES > 1) ? $clog2(NUM_SPARES) : 1;
    localparam int CNT_W = $clog2(NUM_SPARES + 1);

    logic [ADDR_W-1:0]     tag_q  [NUM_SPARES];
    logic [DATA_W-1:0]     data_q [NUM_SPARES];
    logic [NUM_SPARES-1:0] valid_q;
    logic [NUM_SPARES-1:0] look_match;
    logic [NUM_SPARES-1:0] alloc_match;
    logic [IDX_W-1:0]      free_idx;
    logic                  free_found;
    logic                  alloc_do;

    // Lowest-numbered free entry.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = NUM_SPARES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign alloc_do = alloc_req && !(|alloc_match) && free_found;

    for (genvar g = 0; g < NUM_SPARES; g++) begin : g_entry
        assign look_match[g]  = valid_q[g] && (tag_q[g] == look_addr);
        assign alloc_match[g] = valid_q[g] && (tag_q[g] == alloc_addr);

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
                data_q[g]  <= '0;
            end else if (alloc_do && (free_idx == IDX_W'(g))) begin
                valid_q[g] <= 1'b1;
                tag_q[g]   <= alloc_addr;
                data_q[g]  <= '0;
            end else if (wr_en && look_match[g]) begin
                data_q[g]  <= wr_data;
            end
        end
    end

    // Tags are unique, so an OR of the gated words selects the single match.
    always_comb begin
        hit_data = '0;
        for (int i = 0; i < NUM_SPARES; i++) begin
            hit_data = hit_data | (data_q[i] & {DATA_W{look_match[i]}});
        end
    end

    assign hit = |look_match;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            used_count <= '0;
            overflow   <= 1'b0;
        end else if (alloc_req && !(|alloc_match)) begin
            if (free_found) begin
                used_count <= used_count + CNT_W'(1);
            end else begin
                overflow <= 1'b1;
            end
        end
    end

    assign valid_vec = valid_q;

endmodule

// File: rtl/spare_word_repair.sv
module spare_word_repair
    import spare_repair_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16,
    parameter int NUM_SPARES = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            test_start,
    output logic                            test_busy,
    output logic                            test_done,
    output logic                            spare_overflow,
    output logic [$clog2(NUM_SPARES+1)-1:0] mapped_count,
    output logic [NUM_SPARES-1:0]           spare_valid,
    input  logic                            cpu_req,
    input  logic                            cpu_we,
    input  logic [ADDR_W-1:0]               cpu_addr,
    input  logic [DATA_W-1:0]               cpu_wdata,
    output logic [DATA_W-1:0]               cpu_rdata,
    output logic                            cpu_stall,
    output logic                            mem_en,
    output logic                            mem_we,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic [DATA_W-1:0]               mem_wdata,
    input  logic [DATA_W-1:0]               mem_rdata
);

    logic              seq_busy;
    logic              seq_clear;
    logic              seq_en;
    logic              seq_we;
    logic [ADDR_W-1:0] seq_addr;
    logic [DATA_W-1:0] seq_wdata;
    logic              seq_alloc;
    logic [ADDR_W-1:0] seq_alloc_addr;
    logic              cpu_go;
    logic              spare_hit;
    logic [DATA_W-1:0] spare_data;

    march_sequencer #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (test_start),
        .rd_data   (mem_rdata),
        .busy      (seq_busy),
        .done      (test_done),
        .clear_map (seq_clear),
        .mem_en    (seq_en),
        .mem_we    (seq_we),
        .mem_addr  (seq_addr),
        .mem_wdata (seq_wdata),
        .alloc_req (seq_alloc),
        .alloc_addr(seq_alloc_addr)
    );

    assign cpu_go = cpu_req && !seq_busy;

    spare_tag_store #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_SPARES(NUM_SPARES)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .clear     (seq_clear),
        .look_addr (cpu_addr),
        .wr_en     (cpu_go && cpu_we),
        .wr_data   (cpu_wdata),
        .hit       (spare_hit),
        .hit_data  (spare_data),
        .alloc_req (seq_alloc),
        .alloc_addr(seq_alloc_addr),
        .valid_vec (spare_valid),
        .used_count(mapped_count),
        .overflow  (spare_overflow)
    );

    // External port: owned by the sweep while it runs, by the processor otherwise.
    always_comb begin
        if (seq_busy) begin
            mem_en    = seq_en;
            mem_we    = seq_we;
            mem_addr  = seq_addr;
            mem_wdata = seq_wdata;
        end else begin
            mem_en    = cpu_go;
            mem_we    = cpu_go && cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end
    end

    assign cpu_rdata = spare_hit ? spare_data : mem_rdata;
    assign cpu_stall = seq_busy;
    assign test_busy = seq_busy;

endmodule

// File: rtl/spare_repair_checker.sv
module spare_repair_checker #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16,
    parameter int NUM_SPARES = 8
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            test_start,
    input logic                            test_busy,
    input logic                            test_done,
    input logic                            spare_overflow,
    input logic [$clog2(NUM_SPARES+1)-1:0] mapped_count,
    input logic [NUM_SPARES-1:0]           spare_valid,
    input logic                            cpu_stall
);

    localparam int CNT_W = $clog2(NUM_SPARES + 1);

    AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        test_busy |-> cpu_stall); // R5

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (test_done && !test_start) |=> test_done); // R5

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        (spare_overflow && !test_start) |=> spare_overflow); // R4

    AST_OVERFLOW_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(spare_overflow) |-> (&spare_valid)); // R4

    AST_COUNT_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        !test_start |=> ((mapped_count - $past(mapped_count)) <= CNT_W'(1))); // R3

    AST_COUNT_MATCHES_VALID: assert property (@(posedge clk) disable iff (rst)
        (CNT_W'($countones(spare_valid)) == mapped_count)); // R3

    AST_MAP_FROZEN_OUTSIDE_TEST: assert property (@(posedge clk) disable iff (rst)
        (!test_busy && !test_start) |=> $stable(spare_valid)); // R3

    AST_START_CLEARS_MAP: assert property (@(posedge clk) disable iff (rst)
        (test_start && !test_busy) |=> (mapped_count == '0 && !spare_overflow)); // R9

endmodule

bind spare_word_repair spare_repair_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_SPARES(NUM_SPARES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .test_start    (test_start),
    .test_busy     (test_busy),
    .test_done     (test_done),
    .spare_overflow(spare_overflow),
    .mapped_count  (mapped_count),
    .spare_valid   (spare_valid),
    .cpu_stall     (cpu_stall)
);

// File: tb/spare_word_repair_test.sv
module spare_word_repair_test;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 16;
    localparam int NSP    = 8;
    localparam int CNT_W  = $clog2(NSP + 1);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NFAULT = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              test_start = 1'b0;
    logic              test_busy, test_done, spare_overflow, cpu_stall;
    logic [CNT_W-1:0]  mapped_count;
    logic [NSP-1:0]    spare_valid;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    int checks = 0;
    int fails  = 0;
    int active_faults = 0;

    always #4 clk = ~clk;

    spare_word_repair #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SPARES(NSP)) uut (
        .clk(clk), .rst(rst), .test_start(test_start), .test_busy(test_busy),
        .test_done(test_done), .spare_overflow(spare_overflow),
        .mapped_count(mapped_count), .spare_valid(spare_valid),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Faulty external memory: stuck bits per address.
    localparam logic [ADDR_W-1:0] F_ADDR [NFAULT] = '{10'd3, 10'd100, 10'd513, 10'd700, 10'd1023,
                                                      10'd20, 10'd40, 10'd60, 10'd80, 10'd900};
    localparam logic [DATA_W-1:0] F_MASK [NFAULT] = '{16'h0001, 16'h0002, 16'h0001, 16'h00FF, 16'h8000,
                                                      16'h0100, 16'h0004, 16'hF000, 16'h0010, 16'h000F};
    localparam logic [DATA_W-1:0] F_VAL  [NFAULT] = '{16'h0000, 16'h0002, 16'h0001, 16'h0000, 16'h0000,
                                                      16'h0100, 16'h0000, 16'hF000, 16'h0010, 16'h000F};

    logic [DATA_W-1:0] mem_store [DEPTH];

    function automatic logic [DATA_W-1:0] faulty_view(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] raw, int nf);
        logic [DATA_W-1:0] v = raw;
        for (int i = 0; i < NFAULT; i++) begin
            if (i < nf && a == F_ADDR[i]) v = (v & ~F_MASK[i]) | (F_VAL[i] & F_MASK[i]);
        end
        return v;
    endfunction

    assign mem_rdata = faulty_view(mem_addr, mem_store[mem_addr], active_faults);

    always @(posedge clk) begin
        if (mem_en && mem_we) mem_store[mem_addr] <= mem_wdata;
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        test_start = 1'b1;
        @(negedge clk);
        test_start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!test_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check("R5", "test_done after sweep", 32'(test_done), 32'd1);
    endtask

    task automatic cpu_read(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] exp, string req);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1;
        check(req, $sformatf("read addr %0d", a), 32'(cpu_rdata), 32'(exp));
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic cpu_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] exp;
        logic [3:0]        req;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 10'd3,    16'h0000, 16'h0000, 4'd8},  // R8 new spare reads zero
        '{1'b1, 10'd3,    16'hBEEF, 16'h0000, 4'd7},
        '{1'b0, 10'd3,    16'h0000, 16'hBEEF, 4'd7},  // R7 external would give BEEE
        '{1'b1, 10'd100,  16'h1111, 16'h0000, 4'd7},
        '{1'b0, 10'd100,  16'h0000, 16'h1111, 4'd7},  // R7 external would give 1113
        '{1'b0, 10'd513,  16'h0000, 16'h0000, 4'd8},  // R8
        '{1'b1, 10'd5,    16'h2222, 16'h0000, 4'd6},
        '{1'b0, 10'd5,    16'h0000, 16'h2222, 4'd6},  // R6 miss uses external
        '{1'b0, 10'd6,    16'h0000, 16'h5A5A, 4'd2},  // R2 healthy word holds inverse
        '{1'b0, 10'd0,    16'h0000, 16'h5A5A, 4'd5},  // R5 write during sweep ignored
        '{1'b1, 10'd700,  16'hCAFE, 16'h0000, 4'd7},
        '{1'b0, 10'd700,  16'h0000, 16'hCAFE, 4'd7},  // R7 both-pass fault
        '{1'b0, 10'd1023, 16'h0000, 16'h0000, 4'd8}   // R8 last address mapped
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog: actual still running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_store[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "count in reset", 32'(mapped_count), 32'd0);
        check("R1", "valid in reset", 32'(spare_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "done/busy/ovf/stall after reset",
              {28'd0, test_done, test_busy, spare_overflow, cpu_stall}, 32'd0);
        check("R1", "count after reset", 32'(mapped_count), 32'd0);

        // First sweep: five faults, one failing both passes
        active_faults = 5;
        pulse_start();
        check("R5", "busy and stall during sweep", {30'd0, test_busy, cpu_stall}, 32'd3);
        check("R5", "done low during sweep", 32'(test_done), 32'd0);
        repeat (20) @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 10'd0; cpu_wdata = 16'h7777;
        repeat (3) @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        wait_done();
        check("R3", "mapped count, five faults", 32'(mapped_count), 32'd5);
        check("R3", "low entries valid", 32'(spare_valid), 32'h1F);
        check("R4", "no overflow", 32'(spare_overflow), 32'd0);
        check("R2", "healthy word 1022 holds inverse", 32'(mem_store[1022]), 32'h5A5A);
        check("R2", "healthy word 514 holds inverse", 32'(mem_store[514]), 32'h5A5A);

        // Table of processor accesses (R10: read data sampled in the request cycle)
        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v].we) begin
                cpu_write(VECS[v].addr, VECS[v].wdata);
            end else begin
                cpu_read(VECS[v].addr, VECS[v].exp, $sformatf("R%0d/R10", VECS[v].req));
            end
        end
        check("R5", "done holds after accesses", 32'(test_done), 32'd1);

        // Second sweep: ten faults, eight spares
        active_faults = 10;
        pulse_start();
        check("R9", "count cleared at start", 32'(mapped_count), 32'd0);
        check("R9", "valid cleared at start", 32'(spare_valid), 32'd0);
        wait_done();
        check("R4", "count saturates", 32'(mapped_count), 32'd8);
        check("R3", "all entries valid", 32'(spare_valid), 32'hFF);
        check("R4", "overflow set", 32'(spare_overflow), 32'd1);
        cpu_read(10'd20, 16'h0000, "R8");
        cpu_read(10'd3, 16'h0000, "R9");
        cpu_write(10'd900, 16'h1234);
        cpu_read(10'd900, 16'h123F, "R4");
        cpu_write(10'd80, 16'h4321);
        cpu_read(10'd80, 16'h4321, "R7");
        repeat (4) @(negedge clk);
        check("R4", "overflow sticky", 32'(spare_overflow), 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule